// File: doc/BRIEF.md
# Dual 13-bit Prescaled Timer

This block holds two timer channels that count in a 13-bit mode. Each channel is kept in two byte registers, a high byte and a low byte. The bottom five bits of the low byte form a divide-by-32 prescaler, and the 8-bit high byte counts above it. When the prescaler wraps from 31 to 0, the high byte steps once. The 13-bit value of a channel is `{high, low[4:0]}`.

A single-cycle strobe, `cyc_stb`, marks each machine cycle. When a channel's run bit is set, that channel advances by one on every strobe. When the count wraps from 1FFFh to zero, the channel sets a sticky overflow flag and goes on counting from zero.

Software reaches the block through a byte-wide register bus. Through that bus it preloads the counts, starts and stops the channels, and clears the overflow flags.

Top module: `tmr13_pair`

## Requirements
- R1: After reset, every register reads 00h and both `ovf0` and `ovf1` are low.
- R2: The register addresses are as follows. 0 is control, 1 is mode (read/write storage), 2 is channel 0 low, 3 is channel 0 high, 4 is channel 1 low and 5 is channel 1 high. Control bits: bit 4 is run0, bit 5 is ovf0, bit 6 is run1 and bit 7 is ovf1. Control bits 3:0 always read 0. Written values read back on `bus_rdata` in the same cycle that `bus_addr` selects them.
- R3: A channel whose run bit is set advances its 13-bit value `{high, low[4:0]}` by one on each clock with `cyc_stb` high. The high byte steps when `low[4:0]` wraps from 31 to 0.
- R4: A channel keeps its count unchanged while its run bit is clear, and also on any clock where `cyc_stb` is low.
- R5: Counting never changes `low[7:5]`. Those bits keep the value last written to them.
- R6: A step from 1FFFh sets the channel's overflow flag, and counting goes on from 0000h.
- R7: An overflow flag stays set after its run bit is cleared. Only a bus write to control changes a flag, and a written 0 clears it.
- R8: If a bus write to a count byte lands in the same clock as a step, the written byte takes the bus value. The other byte still follows the step.
- R9: The two channels count independently of each other. Each run bit gates only its own channel.
- R10: Output `ovf0` equals control bit 5, and output `ovf1` equals control bit 7.

Two of these can be checked together. With both channels overflowed and stopped, control reads A0h (this covers R6 and R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_stb | input | 1 | Machine-cycle count strobe |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| ovf0 | output | 1 | Channel 0 overflow flag |
| ovf1 | output | 1 | Channel 1 overflow flag |

## Verification
Each channel keeps its entire state in its two count bytes and two control bits, and all of them can be read on the bus. A wrong increment or a wrong carry into the high byte therefore shows in the very next read of that channel. A lost or spurious overflow shows at once on `ovf0`/`ovf1`, and as a control readback such as D0h or A0h instead of the value the model predicts. The bench compares each channel against an arithmetic model: the start value plus the number of strobes, modulo 8192. It runs this comparison for short runs, for runs that wrap, for the exact 1FFFh boundary and for a write that collides with a step.

// File: rtl/tmr13_pair.sv
module tmr13_pair #(
  parameter int PRE_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_stb,
  input  logic       bus_we,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       ovf0,
  output logic       ovf1
);
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_MODE = 3'd1;

  logic [1:0][7:0] lo_q, hi_q;
  logic [1:0]      run_q, ovf_q;
  logic [7:0]      mode_q;

  wire ctrl_wr = bus_we && bus_addr == A_CTRL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      run_q  <= '0;
      ovf_q  <= '0;
      mode_q <= '0;
    end else begin
      if (bus_we && bus_addr == A_MODE) mode_q <= bus_wdata;
      for (int ch = 0; ch < 2; ch++) begin
        logic step, wrap;
        step = cyc_stb && run_q[ch];
        wrap = &lo_q[ch][PRE_W-1:0];
        if (bus_we && bus_addr == 3'(2 + 2*ch))
          lo_q[ch] <= bus_wdata;
        else if (step)
          lo_q[ch][PRE_W-1:0] <= lo_q[ch][PRE_W-1:0] + 1'b1;
        if (bus_we && bus_addr == 3'(3 + 2*ch))
          hi_q[ch] <= bus_wdata;
        else if (step && wrap)
          hi_q[ch] <= hi_q[ch] + 8'd1;
        if (ctrl_wr) begin
          run_q[ch] <= bus_wdata[4 + 2*ch];
          ovf_q[ch] <= bus_wdata[5 + 2*ch];
        end else if (step && wrap && (&hi_q[ch])) begin
          ovf_q[ch] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = {ovf_q[1], run_q[1], ovf_q[0], run_q[0], 4'h0};
      3'd1:    bus_rdata = mode_q;
      3'd2:    bus_rdata = lo_q[0];
      3'd3:    bus_rdata = hi_q[0];
      3'd4:    bus_rdata = lo_q[1];
      3'd5:    bus_rdata = hi_q[1];
      default: bus_rdata = 8'h00;
    endcase
  end

  assign ovf0 = ovf_q[0];
  assign ovf1 = ovf_q[1];
endmodule

// File: rtl/tmr13_pair_chk.sv
module tmr13_pair_chk #(
  parameter int PRE_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cyc_stb,
  input logic            bus_we,
  input logic [2:0]      bus_addr,
  input logic [7:0]      bus_wdata,
  input logic [1:0][7:0] lo_q,
  input logic [1:0][7:0] hi_q,
  input logic [1:0]      run_q,
  input logic [1:0]      ovf_q
);
  for (genvar g = 0; g < 2; g++) begin : g_ch
    localparam logic [2:0] LO = 3'(2 + 2*g);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(cyc_stb && run_q[g]) && !(bus_we && bus_addr == LO)) |=> $stable(lo_q[g]));

    // R5
    upper_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_addr == LO) |=> $stable(lo_q[g][7:PRE_W]));

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_stb && run_q[g] && !(bus_we && bus_addr == LO)) |=>
      lo_q[g][PRE_W-1:0] == PRE_W'($past(lo_q[g][PRE_W-1:0]) + 1'b1));

    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q[g]) |-> ($past(bus_we && bus_addr == 3'd0) ||
        $past(cyc_stb && run_q[g] && (&hi_q[g]) && (&lo_q[g][PRE_W-1:0]))));

    // R7
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ovf_q[g]) |-> $past(bus_we && bus_addr == 3'd0 && !bus_wdata[5 + 2*g]));
  end
endmodule

bind tmr13_pair tmr13_pair_chk #(.PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .lo_q(lo_q), .hi_q(hi_q),
  .run_q(run_q), .ovf_q(ovf_q)
);

// File: tb/sim_tmr13_pair.sv
`timescale 1ns/1ps
module sim_tmr13_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_stb = 1'b0;
  logic       bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ovf0, ovf1;

  tmr13_pair u0 (.*);

  always #5 clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  int    exp_q[$];
  string tag_q[$];
  int    act_v;
  event  obs_ev;

  always begin
    @(obs_ev);
    if (exp_q.size() == 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0h with no expected item", act_v);
    end else begin
      int e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      n_chk++;
      if (act_v != e) begin
        n_fail++;
        $display("FAIL %s: actual %0h expected %0h", t, act_v, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic observe(int act, int e, string t);
    exp_q.push_back(e); tag_q.push_back(t);
    act_v = act;
    -> obs_ev;
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(logic [2:0] a, int e, string t);
    @(negedge clk);
    bus_addr = a;
    #1;
    observe(int'(bus_rdata), e, t);
  endtask

  task automatic strobes(int n);
    @(negedge clk);
    cyc_stb = 1'b1;
    repeat (n) @(negedge clk);
    cyc_stb = 1'b0;
  endtask

  task automatic expect_timer(int ch, int hi, int lo, int n, string t);
    int v;
    v = ((hi << 5) + (lo & 31) + n) % 8192;
    rd_chk(3'(2 + 2*ch), (lo & 8'hE0) | (v & 31), t);
    rd_chk(3'(3 + 2*ch), v >> 5, t);
  endtask

  task automatic load(int ch, int hi, int lo);
    wr(3'(3 + 2*ch), 8'(hi));
    wr(3'(2 + 2*ch), 8'(lo));
  endtask

  initial begin
    #500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(3'd0, 8'h00, "R1 ctrl");
    rd_chk(3'd2, 8'h00, "R1 t0 low");
    rd_chk(3'd5, 8'h00, "R1 t1 high");
    observe({ovf1, ovf0}, 0, "R1 ovf pins");

    // R2 register access
    wr(3'd1, 8'h00);
    rd_chk(3'd1, 8'h00, "R2 mode");
    load(0, 8'h02, 8'h55);
    load(1, 8'hFF, 8'h03);
    rd_chk(3'd3, 8'h02, "R2 t0 high");
    rd_chk(3'd2, 8'h55, "R2 t0 low");
    rd_chk(3'd4, 8'h03, "R2 t1 low");
    wr(3'd0, 8'h0F);
    rd_chk(3'd0, 8'h00, "R2 ctrl low bits read 0");

    // R4 stopped channels hold under strobes
    strobes(20);
    expect_timer(0, 8'h02, 8'h55, 0, "R4 t0 stopped");
    expect_timer(1, 8'hFF, 8'h03, 0, "R4 t1 stopped");

    // R4 running but strobe low
    wr(3'd0, 8'h50);
    repeat (5) @(negedge clk);
    expect_timer(0, 8'h02, 8'h55, 0, "R4 no strobe");

    // R3 R5 R6 counting, t1 wraps
    strobes(100);
    expect_timer(0, 8'h02, 8'h55, 100, "R3 R5 t0 100 steps");
    expect_timer(1, 8'hFF, 8'h03, 100, "R6 t1 wrapped");
    rd_chk(3'd0, 8'hD0, "R6 ctrl run+ovf1");
    observe(ovf1, 1, "R10 ovf1 pin");

    // R7 stop, flag stays
    wr(3'd0, 8'hD0 & 8'hAF);
    rd_chk(3'd0, 8'h80, "R7 ovf1 kept after stop");
    strobes(10);
    expect_timer(1, 8'hFF, 8'h03, 100, "R4 t1 held after stop");

    // R6 exact boundary, R9 only t0 runs
    load(0, 8'hFF, 8'hFF);
    load(1, 8'h12, 8'h04);
    wr(3'd0, 8'h90);
    strobes(1);
    rd_chk(3'd2, 8'hE0, "R6 R5 t0 low after 1FFF");
    rd_chk(3'd3, 8'h00, "R6 t0 high after 1FFF");
    observe({ovf1, ovf0}, 3, "R10 both ovf pins");
    expect_timer(1, 8'h12, 8'h04, 0, "R9 t1 untouched");

    // R7 both stopped and overflowed
    wr(3'd0, 8'hB0 & 8'hAF);
    rd_chk(3'd0, 8'hA0, "R7 ctrl A0");
    strobes(5);
    rd_chk(3'd0, 8'hA0, "R7 ctrl after strobes");
    wr(3'd0, 8'h80);
    rd_chk(3'd0, 8'h80, "R7 ovf0 cleared by write");
    observe(ovf0, 0, "R7 ovf0 pin low");

    // R8 write collides with step
    load(0, 8'h10, 8'h1F);
    wr(3'd0, 8'h90);
    @(negedge clk);
    cyc_stb = 1'b1; bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h05;
    @(negedge clk);
    cyc_stb = 1'b0; bus_we = 1'b0;
    rd_chk(3'd2, 8'h05, "R8 low takes write");
    rd_chk(3'd3, 8'h11, "R8 high follows step");

    // R3 R6 long run with wrap on t0
    wr(3'd0, 8'h00);
    load(0, 8'hF0, 8'h01);
    wr(3'd0, 8'h10);
    strobes(1000);
    expect_timer(0, 8'hF0, 8'h01, 1000, "R3 t0 1000 steps");
    observe(ovf0, 1, "R6 t0 wrap flag");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule